// File: doc/BRIEF.md
# Prefixed Shift Execution Unit

This unit carries out the three shift operations of the prefixed opcode group of an 8-bit processor. A one-cycle start strobe hands it an opcode byte. The opcode names the kind of shift and the operand. The operand is one of seven byte registers, or the byte in memory whose address is formed by the H and L registers (H high, L low). The unit shifts the operand and writes the result back to where the operand came from. It also updates the four condition flags and raises a one-cycle done pulse once the fixed cycle count for that operand class has elapsed.

Register operands finish in eight cycles. A memory operand is handled as a read-modify-write over a synchronous byte port with one cycle of read latency and finishes in sixteen cycles. Opcodes outside the shift group are refused: the unit flags them, completes at once and changes nothing. A load port places values in the register file while the unit is idle. The whole register file and the flags are visible as outputs.

Top module: `shift_exec_unit`

## Requirements
- R1: Opcodes 0x20-0x27 select left shift, 0x28-0x2F select arithmetic right shift, and 0x38-0x3F select logical right shift. Opcode bits [2:0] select the operand: 7=A, 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory at {H,L}. Register slot k appears on `reg_view[8k+7:8k]`, and slot 6 always reads 0.
- R2: Left shift: the result is the operand moved up one bit with 0 entering bit 0, truncated to 8 bits. Carry takes the old bit 7.
- R3: Arithmetic right shift: the result is the operand moved down one bit with the old bit 7 kept in bit 7. Carry takes the old bit 0.
- R4: Logical right shift: the result is the operand moved down one bit with 0 entering bit 7. Carry takes the old bit 0.
- R5: `flags_out` is {Z,N,H,C} in bits 3..0. After every shift, Z is 1 exactly when the 8-bit result is 0, and N and H are 0.
- R6: For a register operand, done is high in the 8th cycle, counting the start cycle as the 1st. The result and the flags are written at the end of that cycle, into the selected register only. No memory access takes place.
- R7: For a memory operand, done is high in the 16th cycle. The unit makes exactly one read at {H,L} and, after capturing the read data, exactly one write of the result to the same address. No register changes.
- R8: Done lasts exactly one cycle. Busy is high from the cycle after start up to and including the done cycle of a legal operation.
- R9: Any other opcode raises illegal together with done for the single cycle after start. It changes no register or flag and makes no memory access.
- R10: Start is ignored while busy is high and in the done cycle of a refused opcode.
- R11: Synchronous active-high reset returns the unit to idle, clears all registers and flags, and aborts any operation in progress.
- R12: When `ld_en` is high and the unit is idle, `ld_data` is written into slot `ld_sel` (slot 6 is ignored). When the unit is busy, loads are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, sampled while idle |
| opcode | input | 8 | Prefixed opcode byte |
| ld_en | input | 1 | Register load enable (idle only) |
| ld_sel | input | 3 | Register slot to load |
| ld_data | input | 8 | Value to load |
| mem_addr | output | 16 | Memory address, {H,L} |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Read data, valid one cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Refused opcode pulse |
| reg_view | output | 64 | Register file, slot k in bits 8k+7:8k |
| flags_out | output | 4 | Flags {Z,N,H,C} |

## Verification
The assertions assume that the memory returns read data in exactly the cycle after the read strobe. They also assume that start is a clean strobe, so that a refused opcode yields a single isolated done. The bench memory model answers with that fixed latency. The bench holds start for one cycle only, except in the test where start is deliberately re-asserted while the unit is busy. The bench issues loads only while the unit is idle, apart from the one load made on purpose during a busy operation.

// File: rtl/shx_pkg.sv
package shx_pkg;

    localparam int DATA_W   = 8;
    localparam int SLOTS    = 8;
    localparam int SEL_W    = $clog2(SLOTS);
    localparam logic [SEL_W-1:0] MEM_SLOT = 3'd6;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_ARITH = 2'd1,
        SH_LOGIC = 2'd3
    } sh_kind_t;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } sh_flags_t;

    typedef struct packed {
        logic             legal;
        sh_kind_t         kind;
        logic [SEL_W-1:0] sel;
        logic             is_mem;
    } sh_dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        sh_flags_t         flags;
    } sh_out_t;

    function automatic sh_out_t shift_calc(sh_kind_t kind, logic [DATA_W-1:0] v);
        sh_out_t o;
        case (kind)
            SH_LEFT: begin
                o.res     = {v[DATA_W-2:0], 1'b0};
                o.flags.c = v[DATA_W-1];
            end
            SH_ARITH: begin
                o.res     = {v[DATA_W-1], v[DATA_W-1:1]};
                o.flags.c = v[0];
            end
            default: begin
                o.res     = {1'b0, v[DATA_W-1:1]};
                o.flags.c = v[0];
            end
        endcase
        o.flags.z = (o.res == '0);
        o.flags.n = 1'b0;
        o.flags.h = 1'b0;
        return o;
    endfunction

endpackage

// File: rtl/shx_decode.sv
module shx_decode
    import shx_pkg::*;
(
    input  logic [7:0] opcode,
    output sh_dec_t    dec
);
    always_comb begin
        dec.sel    = opcode[SEL_W-1:0];
        dec.is_mem = (opcode[SEL_W-1:0] == MEM_SLOT);
        dec.legal  = (opcode[7:5] == 3'b001) && (opcode[4:3] != 2'b10);
        case (opcode[4:3])
            2'b00:   dec.kind = SH_LEFT;
            2'b01:   dec.kind = SH_ARITH;
            default: dec.kind = SH_LOGIC;
        endcase
    end
endmodule

// File: rtl/shx_alu.sv
module shx_alu
    import shx_pkg::*;
(
    input  sh_kind_t          kind,
    input  logic [DATA_W-1:0] operand,
    output sh_out_t           out
);
    always_comb out = shift_calc(kind, operand);
endmodule

// File: rtl/shx_regfile.sv
module shx_regfile
    import shx_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ld_en,
    input  logic [SEL_W-1:0]         ld_sel,
    input  logic [DATA_W-1:0]        ld_data,
    input  logic                     wb_en,
    input  logic [SEL_W-1:0]         wb_sel,
    input  logic [DATA_W-1:0]        wb_data,
    output logic [SLOTS*DATA_W-1:0]  view
);
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        if (k == int'(MEM_SLOT)) begin : g_hole
            assign view[k*DATA_W +: DATA_W] = '0;
        end else begin : g_reg
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (wb_en && wb_sel == SEL_W'(k))
                    q <= wb_data;
                else if (ld_en && ld_sel == SEL_W'(k))
                    q <= ld_data;
            end
            assign view[k*DATA_W +: DATA_W] = q;
        end
    end
endmodule

// File: rtl/shift_exec_unit.sv
module shift_exec_unit
    import shx_pkg::*;
#(
    parameter int REG_CYCLES = 8,
    parameter int MEM_CYCLES = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [7:0]              opcode,
    input  logic                    ld_en,
    input  logic [SEL_W-1:0]        ld_sel,
    input  logic [DATA_W-1:0]       ld_data,
    output logic [2*DATA_W-1:0]     mem_addr,
    output logic                    mem_rd_en,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic                    mem_wr_en,
    output logic [DATA_W-1:0]       mem_wdata,
    output logic                    busy,
    output logic                    done,
    output logic                    illegal,
    output logic [SLOTS*DATA_W-1:0] reg_view,
    output logic [3:0]              flags_out
);
    localparam int CNT_W   = $clog2(MEM_CYCLES + 1);
    localparam int RD_AT   = 1;
    localparam int CAP_AT  = RD_AT + 1;
    localparam int WR_AT   = MEM_CYCLES - 2;
    localparam int SLOT_H  = 4;
    localparam int SLOT_L  = 5;

    sh_dec_t           dec;
    sh_out_t           alu_o;
    logic              busy_q, ill_q, mem_q;
    logic [CNT_W-1:0]  cnt_q;
    sh_kind_t          kind_q;
    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] data_q, operand;
    sh_flags_t         flags_q;
    logic              accept, last, wb_en;

    shx_decode u_dec (.opcode(opcode), .dec(dec));

    assign operand = mem_q ? data_q : reg_view[sel_q*DATA_W +: DATA_W];

    shx_alu u_alu (.kind(kind_q), .operand(operand), .out(alu_o));

    assign accept = start && !busy_q && !ill_q;
    assign last   = busy_q && (cnt_q == (mem_q ? CNT_W'(MEM_CYCLES - 1)
                                               : CNT_W'(REG_CYCLES - 1)));
    assign wb_en  = last && !mem_q;

    shx_regfile u_rf (
        .clk(clk), .rst(rst),
        .ld_en(ld_en && !busy_q), .ld_sel(ld_sel), .ld_data(ld_data),
        .wb_en(wb_en), .wb_sel(sel_q), .wb_data(alu_o.res),
        .view(reg_view)
    );

    assign mem_addr  = {reg_view[SLOT_H*DATA_W +: DATA_W], reg_view[SLOT_L*DATA_W +: DATA_W]};
    assign mem_rd_en = busy_q && mem_q && (cnt_q == CNT_W'(RD_AT));
    assign mem_wr_en = busy_q && mem_q && (cnt_q == CNT_W'(WR_AT));
    assign mem_wdata = alu_o.res;
    assign busy      = busy_q;
    assign done      = last || ill_q;
    assign illegal   = ill_q;
    assign flags_out = flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            ill_q   <= 1'b0;
            mem_q   <= 1'b0;
            cnt_q   <= '0;
            kind_q  <= SH_LEFT;
            sel_q   <= '0;
            data_q  <= '0;
            flags_q <= '0;
        end else begin
            ill_q <= accept && !dec.legal;
            if (accept && dec.legal) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_W'(1);
                kind_q <= dec.kind;
                sel_q  <= dec.sel;
                mem_q  <= dec.is_mem;
            end else if (busy_q) begin
                if (last) begin
                    busy_q  <= 1'b0;
                    cnt_q   <= '0;
                    flags_q <= alu_o.flags;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
            if (busy_q && mem_q && cnt_q == CNT_W'(CAP_AT))
                data_q <= mem_rdata;
        end
    end
endmodule

// File: rtl/shx_checker.sv
module shx_checker (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        illegal,
    input logic        mem_rd_en,
    input logic        mem_wr_en,
    input logic [15:0] mem_addr,
    input logic [63:0] reg_view,
    input logic [3:0]  flags_out
);
    logic seen_rd;
    always_ff @(posedge clk) begin
        if (rst || done)
            seen_rd <= 1'b0;
        else if (mem_rd_en)
            seen_rd <= 1'b1;
    end

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_busy_at_done_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !illegal) |-> busy);
    p_busy_drops_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !illegal) |=> !busy);
    p_rd_wr_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));
    p_wr_after_rd_r7: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> seen_rd);
    p_rd_addr_hl_r7: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (mem_addr == {reg_view[39:32], reg_view[47:40]}));
    p_illegal_done_r9: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (done && !busy && !mem_rd_en && !mem_wr_en));
    p_illegal_flags_r9: assert property (@(posedge clk) disable iff (rst)
        illegal |=> $stable(flags_out));
    p_hole_zero_r1: assert property (@(posedge clk) disable iff (rst)
        reg_view[55:48] == 8'h00);
endmodule

bind shift_exec_unit shx_checker u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .illegal(illegal),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .reg_view(reg_view), .flags_out(flags_out)
);

// File: tb/shift_exec_unit_test.sv
`timescale 1ns/100ps
module shift_exec_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_sel = 3'd0;
    logic [7:0]  ld_data = 8'h00;
    logic [15:0] mem_addr;
    logic        mem_rd_en, mem_wr_en;
    logic [7:0]  mem_rdata = 8'h00;
    logic [7:0]  mem_wdata;
    logic        busy, done, illegal;
    logic [63:0] reg_view;
    logic [3:0]  flags_out;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [7:0]  mem [0:255];
    int          rd_cnt = 0, wr_cnt = 0;
    bit          order_bad = 1'b0;
    logic [15:0] last_wr_addr = 16'h0;

    always #2.5 clk = ~clk;

    shift_exec_unit uut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata),
        .busy(busy), .done(done), .illegal(illegal),
        .reg_view(reg_view), .flags_out(flags_out)
    );

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr[7:0]];
            rd_cnt    <= rd_cnt + 1;
        end
        if (mem_wr_en) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            wr_cnt       <= wr_cnt + 1;
            last_wr_addr <= mem_addr;
            if (rd_cnt == 0) order_bad <= 1'b1;
        end
    end

    // {opcode, operand, result, flags ZNHC}
    localparam int NV = 12;
    localparam logic [27:0] VEC [NV] = '{
        {8'h27, 8'h80, 8'h00, 4'b1001},
        {8'h20, 8'h41, 8'h82, 4'b0000},
        {8'h21, 8'h00, 8'h00, 4'b1000},
        {8'h2F, 8'h81, 8'hC0, 4'b0001},
        {8'h28, 8'h02, 8'h01, 4'b0000},
        {8'h2D, 8'h01, 8'h00, 4'b1001},
        {8'h3F, 8'h81, 8'h40, 4'b0001},
        {8'h38, 8'hFF, 8'h7F, 4'b0001},
        {8'h3C, 8'h01, 8'h00, 4'b1001},
        {8'h26, 8'hC3, 8'h86, 4'b0001},
        {8'h2E, 8'h80, 8'hC0, 4'b0000},
        {8'h3E, 8'h01, 8'h00, 4'b1001}
    };

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [2:0] sel, input logic [7:0] val);
        ld_en = 1'b1; ld_sel = sel; ld_data = val;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    function automatic string kind_tag(input logic [7:0] op);
        if (op[4:3] == 2'b00) return "R2";
        if (op[4:3] == 2'b01) return "R3";
        return "R4";
    endfunction

    // drives start in the current cycle; returns the index of the done cycle
    task automatic run_op(input logic [7:0] op, output int cyc);
        start = 1'b1; opcode = op; cyc = 0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            start = 1'b0;
            cyc = i;
            if (done) break;
        end
    endtask

    logic [63:0] exp_view;
    int          cyc;

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk("R11", "reset regs", reg_view, 64'h0);
        chk("R11", "reset flags", {60'h0, flags_out}, 64'h0);
        chk("R11", "reset busy/done/illegal", {61'h0, busy, done, illegal}, 64'h0);

        // table walk: R1..R7
        for (int v = 0; v < NV; v++) begin
            logic [7:0] op, val, res;
            logic [3:0] fl;
            logic [2:0] sel;
            {op, val, res, fl} = VEC[v];
            sel = op[2:0];
            exp_view = 64'h0;
            for (int k = 0; k < 8; k++) begin
                if (k != 6) begin
                    load(3'(k), 8'(8'h10 + k));
                    exp_view[8*k +: 8] = 8'(8'h10 + k);
                end
            end
            load(3'd4, 8'h12); exp_view[39:32] = 8'h12;
            load(3'd5, 8'h34); exp_view[47:40] = 8'h34;
            if (sel != 3'd6) begin
                load(sel, val);
                exp_view[8*sel +: 8] = res;
            end else begin
                mem[8'h34] = val;
            end
            rd_cnt = 0; wr_cnt = 0; order_bad = 1'b0;
            run_op(op, cyc);
            if (sel == 3'd6) chk("R7", "mem done cycle", 64'(cyc), 64'd15);
            else             chk("R6", "reg done cycle", 64'(cyc), 64'd7);
            chk("R8", "busy in done cycle", {63'h0, busy}, 64'h1);
            @(negedge clk);
            chk("R8", "done one cycle", {62'h0, done, busy}, 64'h0);
            chk(sel == 3'd6 ? "R7" : "R1", "register file", reg_view, exp_view);
            chk(kind_tag(op), "flags", {60'h0, flags_out}, {60'h0, fl});
            chk("R5", "N/H clear", {62'h0, flags_out[2:1]}, 64'h0);
            if (sel == 3'd6) begin
                chk("R7", "rd/wr counts", {rd_cnt[31:0], wr_cnt[31:0]}, {32'd1, 32'd1});
                chk("R7", "written byte", {56'h0, mem[8'h34]}, {56'h0, res});
                chk("R7", "write addr/order", {47'h0, order_bad, last_wr_addr}, {48'h0, 16'h1234});
            end else begin
                chk("R6", "no mem access", {rd_cnt[31:0], wr_cnt[31:0]}, 64'h0);
            end
        end

        // R9 refused opcodes
        for (int j = 0; j < 4; j++) begin
            logic [7:0] bad;
            logic [63:0] v0;
            logic [3:0]  f0;
            bad = (j == 0) ? 8'h30 : (j == 1) ? 8'h37 : (j == 2) ? 8'h40 : 8'h1F;
            v0 = reg_view; f0 = flags_out;
            rd_cnt = 0; wr_cnt = 0;
            start = 1'b1; opcode = bad;
            @(negedge clk);
            start = 1'b0;
            chk("R9", "illegal+done pulse", {61'h0, illegal, done, busy}, 64'h6);
            @(negedge clk);
            chk("R9", "pulse ends", {62'h0, illegal, done}, 64'h0);
            chk("R9", "regs unchanged", reg_view, v0);
            chk("R9", "flags unchanged", {60'h0, flags_out}, {60'h0, f0});
            chk("R9", "no mem access", {rd_cnt[31:0], wr_cnt[31:0]}, 64'h0);
        end

        // R10 / R12: start and load ignored while busy
        load(3'd7, 8'h81);
        load(3'd0, 8'h55);
        run_op(8'h3F, cyc);
        chk("R10", "first op unaffected", 64'(cyc), 64'd7);
        @(negedge clk);
        chk("R10", "A result", {56'h0, reg_view[63:56]}, 64'h40);
        start = 1'b1; opcode = 8'h3F;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1; opcode = 8'h20;
        ld_en = 1'b1; ld_sel = 3'd0; ld_data = 8'hEE;
        @(negedge clk);
        start = 1'b0; ld_en = 1'b0;
        cyc = 3;
        for (int i = 0; i < 20; i++) begin
            if (done) break;
            @(negedge clk);
            cyc++;
        end
        chk("R10", "done cycle with start while busy", 64'(cyc), 64'd7);
        @(negedge clk);
        chk("R12", "load ignored while busy, B", {56'h0, reg_view[7:0]}, 64'h55);
        chk("R10", "A shifted once more", {56'h0, reg_view[63:56]}, 64'h20);
        begin
            int extra = 0;
            for (int i = 0; i < 12; i++) begin
                if (done || busy) extra++;
                @(negedge clk);
            end
            chk("R10", "no second operation", 64'(extra), 64'd0);
        end

        // R11 reset mid-operation
        load(3'd2, 8'h03);
        start = 1'b1; opcode = 8'h22;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11", "reset aborts", {61'h0, busy, done, illegal}, 64'h0);
        chk("R11", "reset clears regs", reg_view, 64'h0);
        chk("R11", "reset clears flags", {60'h0, flags_out}, 64'h0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule